// File: doc/BRIEF.md
# Flash Write Status Byte Generator

This block forms the byte that a flash device drives onto its data bus when the host reads during an embedded write operation. The operation in progress reaches the block as a mode code from the device's command controller. Several inputs shape the status byte: the byte being programmed, a sector-hit flag, a timing-limit-exceeded flag, the erase-window-closed flag and the array read data.

The block holds two toggle flip-flops. The primary toggle appears on bit 6. The secondary toggle appears on bit 2 and is only meaningful for sectors involved in erase. Each toggle advances on a read strobe while its own per-mode condition holds. The host polls the byte and tells the operations apart by which bits move between reads. The status byte is combinational from the inputs and the toggle state. A toggle flips at the clock edge that ends a strobe cycle, so the next read sees the new value.

Top module: `fs_status_gen`

## Requirements
- R1: After reset both toggle flip-flops hold 0, so the first status read in program mode with programmed bit 7 set returns 0x00 when the timeout flag is low.
- R2: Mode code 0 (idle) and the unused codes 5, 6 and 7 return the array data unchanged on all eight bits.
- R3: Mode code 1 (program) gives bit 7 = inverse of programmed-data bit 7, bit 6 = primary toggle, bit 5 = timeout flag and bit 2 = secondary toggle. Bits 4, 3, 1 and 0 are 0.
- R4: The primary toggle inverts once per clock cycle with the read strobe high when the mode is 1, 2 or 4. In every other cycle it keeps its value.
- R5: Mode code 2 (erase) gives bit 7 = 0, bit 6 = primary toggle, bit 5 = timeout flag, bit 3 = erase-window flag and bit 2 = secondary toggle. Bits 4, 1 and 0 are 0.
- R6: The secondary toggle inverts once per strobe cycle only when the mode is 2 or 3 and the sector-hit flag is high. Otherwise it keeps its value, including during program mode, where bit 2 shows it held.
- R7: Mode code 3 (erase suspended) with sector-hit high gives bit 7 = 1, bit 6 = primary toggle held without change, and bit 2 = secondary toggle. All other bits are 0.
- R8: Mode code 3 with sector-hit low returns the array data unchanged.
- R9: Mode code 4 (program during suspend) gives bit 7 = inverse of programmed-data bit 7, bit 6 = primary toggle and bit 5 = timeout flag. Bits 4, 3, 2, 1 and 0 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Operation code (0 idle, 1 program, 2 erase, 3 erase suspended, 4 program in suspend) |
| rd_strobe | input | 1 | High for one cycle per host status read |
| sector_hit | input | 1 | Read address lies in a sector selected for (or suspended from) erase |
| prog_byte | input | 8 | Byte being programmed |
| limit_hit | input | 1 | Internal pulse-count limit exceeded |
| window_closed | input | 1 | Erase-command acceptance window has ended |
| array_byte | input | 8 | Array read data |
| status_byte | output | 8 | Byte driven on the data bus |

## Verification
The bench targets the secondary toggle outside its home modes. If it moved in program mode, or on an erase read with sector-hit low, the bit 2 pattern would drift away from the model. A suspended-sector read must leave bit 6 frozen across strobes; a design that kept toggling there would make the host think the erase had resumed. The bench also drives the unused mode codes and suspend reads with sector-hit low, where any status bits leaking into array data show up at once. It also checks that the limit flag reaches bit 5 only in the three busy modes.

// File: rtl/fs_status_pkg.sv
package fs_status_pkg;
   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      FS_IDLE      = 3'd0,
      FS_PROG      = 3'd1,
      FS_ERASE     = 3'd2,
      FS_SUSP      = 3'd3,
      FS_SUSP_PROG = 3'd4
   } fs_mode_e;

   // index of each toggle flip-flop in the toggle vector
   localparam int TOG_MAIN = 0;
   localparam int TOG_ALT  = 1;
   localparam int TOG_NUM  = 2;
endpackage

// File: rtl/fs_toggle_ctrl.sv
module fs_toggle_ctrl
   import fs_status_pkg::*;
#(
   parameter bit ALT_HIT_GATE = 1'b1
) (
   input  fs_mode_e            mode_e,
   input  logic                rd_strobe,
   input  logic                sector_hit,
   output logic [TOG_NUM-1:0]  tog_en
);
   logic main_cond;
   logic alt_mode;
   logic alt_cond;

   always_comb begin
      main_cond = (mode_e == FS_PROG) || (mode_e == FS_ERASE) ||
                  (mode_e == FS_SUSP_PROG);
      alt_mode  = (mode_e == FS_ERASE) || (mode_e == FS_SUSP);
   end

   generate
      if (ALT_HIT_GATE) begin : g_alt_gated
         assign alt_cond = alt_mode && sector_hit;
      end else begin : g_alt_free
         assign alt_cond = alt_mode;
      end
   endgenerate

   assign tog_en[TOG_MAIN] = rd_strobe && main_cond;
   assign tog_en[TOG_ALT]  = rd_strobe && alt_cond;
endmodule

// File: rtl/fs_toggle_cell.sv
module fs_toggle_cell #(
   parameter bit INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= INIT;
      else if (en) q <= ~q;
   end

   // R4 R6: one inversion per enabled cycle, hold otherwise
   p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (q != $past(q)));
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (q == $past(q)));
endmodule

// File: rtl/fs_status_mux.sv
module fs_status_mux
   import fs_status_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int POLL_BIT  = 7,
   parameter int MAIN_BIT  = 6,
   parameter int FAIL_BIT  = 5,
   parameter int TIMER_BIT = 3,
   parameter int ALT_BIT   = 2
) (
   input  fs_mode_e            mode_e,
   input  logic                sector_hit,
   input  logic [DATA_W-1:0]   prog_byte,
   input  logic                limit_hit,
   input  logic                window_closed,
   input  logic [DATA_W-1:0]   array_byte,
   input  logic [TOG_NUM-1:0]  tog_q,
   output logic [DATA_W-1:0]   status_byte
);
   always_comb begin
      status_byte = '0;
      case (mode_e)
         FS_PROG: begin
            status_byte[POLL_BIT] = ~prog_byte[POLL_BIT];
            status_byte[MAIN_BIT] = tog_q[TOG_MAIN];
            status_byte[FAIL_BIT] = limit_hit;
            status_byte[ALT_BIT]  = tog_q[TOG_ALT];
         end
         FS_ERASE: begin
            status_byte[MAIN_BIT]  = tog_q[TOG_MAIN];
            status_byte[FAIL_BIT]  = limit_hit;
            status_byte[TIMER_BIT] = window_closed;
            status_byte[ALT_BIT]   = tog_q[TOG_ALT];
         end
         FS_SUSP: begin
            if (sector_hit) begin
               status_byte[POLL_BIT] = 1'b1;
               status_byte[MAIN_BIT] = tog_q[TOG_MAIN];
               status_byte[ALT_BIT]  = tog_q[TOG_ALT];
            end else begin
               status_byte = array_byte;
            end
         end
         FS_SUSP_PROG: begin
            status_byte[POLL_BIT] = ~prog_byte[POLL_BIT];
            status_byte[MAIN_BIT] = tog_q[TOG_MAIN];
            status_byte[FAIL_BIT] = limit_hit;
         end
         default: status_byte = array_byte;
      endcase
   end
endmodule

// File: rtl/fs_status_gen.sv
module fs_status_gen
   import fs_status_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int POLL_BIT     = 7,
   parameter int MAIN_BIT     = 6,
   parameter int FAIL_BIT     = 5,
   parameter int TIMER_BIT    = 3,
   parameter int ALT_BIT      = 2,
   parameter bit ALT_HIT_GATE = 1'b1,
   parameter bit TOG_INIT     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        mode,
   input  logic              rd_strobe,
   input  logic              sector_hit,
   input  logic [DATA_W-1:0] prog_byte,
   input  logic              limit_hit,
   input  logic              window_closed,
   input  logic [DATA_W-1:0] array_byte,
   output logic [DATA_W-1:0] status_byte
);
   localparam int MAX_BIT = DATA_W - 1;

   // elaboration-time parameter checks
   if (DATA_W < 8) begin : g_bad_width
      $error("fs_status_gen: DATA_W must be at least 8");
   end
   if (POLL_BIT > MAX_BIT || MAIN_BIT > MAX_BIT || FAIL_BIT > MAX_BIT ||
       TIMER_BIT > MAX_BIT || ALT_BIT > MAX_BIT) begin : g_bad_pos
      $error("fs_status_gen: status bit position outside the data width");
   end
   if (POLL_BIT == MAIN_BIT || POLL_BIT == FAIL_BIT || POLL_BIT == TIMER_BIT ||
       POLL_BIT == ALT_BIT  || MAIN_BIT == FAIL_BIT || MAIN_BIT == TIMER_BIT ||
       MAIN_BIT == ALT_BIT  || FAIL_BIT == TIMER_BIT || FAIL_BIT == ALT_BIT ||
       TIMER_BIT == ALT_BIT) begin : g_bad_overlap
      $error("fs_status_gen: status bit positions overlap");
   end

   fs_mode_e            mode_e;
   logic [TOG_NUM-1:0]  tog_en;
   logic [TOG_NUM-1:0]  tog_q;

   assign mode_e = fs_mode_e'(mode);

   fs_toggle_ctrl #(.ALT_HIT_GATE(ALT_HIT_GATE)) u_ctrl (
      .mode_e     (mode_e),
      .rd_strobe  (rd_strobe),
      .sector_hit (sector_hit),
      .tog_en     (tog_en)
   );

   for (genvar gi = 0; gi < TOG_NUM; gi++) begin : g_tog
      fs_toggle_cell #(.INIT(TOG_INIT)) u_cell (
         .clk   (clk),
         .rst_n (rst_n),
         .en    (tog_en[gi]),
         .q     (tog_q[gi])
      );
   end

   fs_status_mux #(
      .DATA_W   (DATA_W),
      .POLL_BIT (POLL_BIT),
      .MAIN_BIT (MAIN_BIT),
      .FAIL_BIT (FAIL_BIT),
      .TIMER_BIT(TIMER_BIT),
      .ALT_BIT  (ALT_BIT)
   ) u_mux (
      .mode_e        (mode_e),
      .sector_hit    (sector_hit),
      .prog_byte     (prog_byte),
      .limit_hit     (limit_hit),
      .window_closed (window_closed),
      .array_byte    (array_byte),
      .tog_q         (tog_q),
      .status_byte   (status_byte)
   );

   // R2 R8: pass-through modes present array data
   p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd0 || mode > 3'd4) |-> (status_byte == array_byte));
   p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd3 && !sector_hit) |-> (status_byte == array_byte));
   // R3 R9: polling bit is the inverse of the programmed bit
   p_poll_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd1 || mode == 3'd4) |-> (status_byte[POLL_BIT] != prog_byte[POLL_BIT]));
   p_noalt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd4) |-> (status_byte[ALT_BIT] == 1'b0 && status_byte[TIMER_BIT] == 1'b0));
   // R5: erase reports polling low and the window flag
   p_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd2) |-> (status_byte[POLL_BIT] == 1'b0 &&
                          status_byte[TIMER_BIT] == window_closed));
   // R7: suspended-sector reads keep bit 6 frozen across consecutive reads
   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd3 && sector_hit) |=>
         ((mode == 3'd3 && sector_hit) -> $stable(status_byte[MAIN_BIT])));
   // R6: a program-mode strobe never moves bit 2
   p_altheld_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd1) |=> ((mode == 3'd1) -> $stable(status_byte[ALT_BIT])));
endmodule

// File: tb/tb_fs_status_gen.sv
module tb_fs_status_gen;
   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 3000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] mode = 3'd0;
   logic       rd_strobe = 1'b0;
   logic       sector_hit = 1'b0;
   logic [7:0] prog_byte = 8'h00;
   logic       limit_hit = 1'b0;
   logic       window_closed = 1'b0;
   logic [7:0] array_byte = 8'h00;
   logic [7:0] status_byte;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;
   logic m_main = 1'b0;
   logic m_alt  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fs_status_gen dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .rd_strobe(rd_strobe),
      .sector_hit(sector_hit), .prog_byte(prog_byte), .limit_hit(limit_hit),
      .window_closed(window_closed), .array_byte(array_byte),
      .status_byte(status_byte)
   );

   function automatic logic [7:0] exp_byte(logic [2:0] m, logic hit,
         logic [7:0] pd, logic lim, logic win, logic [7:0] arr,
         logic tm, logic ta);
      logic [7:0] e = 8'h00;
      case (m)
         3'd1: begin e[7] = ~pd[7]; e[6] = tm; e[5] = lim; e[2] = ta; end
         3'd2: begin e[6] = tm; e[5] = lim; e[3] = win; e[2] = ta; end
         3'd3: if (hit) begin e[7] = 1'b1; e[6] = tm; e[2] = ta; end
               else e = arr;
         3'd4: begin e[7] = ~pd[7]; e[6] = tm; e[5] = lim; end
         default: e = arr;
      endcase
      return e;
   endfunction

   function automatic string req_tag(logic [2:0] m, logic hit);
      case (m)
         3'd1: return "R3 R4 R6";
         3'd2: return "R5 R4 R6";
         3'd3: return hit ? "R7 R6" : "R8";
         3'd4: return "R9 R4";
         default: return "R2";
      endcase
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: status=%02h expected=%02h", tag, act, exp);
      end
   endtask

   // drive one cycle, check mid-cycle, then update the toggle model at the edge
   task automatic step(logic [2:0] m, logic stb, logic hit, logic [7:0] pd,
                       logic lim, logic win, logic [7:0] arr);
      @(negedge clk);
      mode = m; rd_strobe = stb; sector_hit = hit; prog_byte = pd;
      limit_hit = lim; window_closed = win; array_byte = arr;
      #1;
      check(req_tag(m, hit), status_byte,
            exp_byte(m, hit, pd, lim, win, arr, m_main, m_alt));
      @(posedge clk);
      if (stb && (m == 3'd1 || m == 3'd2 || m == 3'd4)) m_main = ~m_main;
      if (stb && (m == 3'd2 || m == 3'd3) && hit)       m_alt  = ~m_alt;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: toggles start at 0
      step(3'd1, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0, 8'h5A);
      check("R1", status_byte, 8'h00);
      // R2: idle and unused codes pass array data
      step(3'd0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 8'hA5);
      step(3'd6, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h3C);
      // R4 R6: three program reads flip bit 6, bit 2 stays
      for (int i = 0; i < 3; i++) step(3'd1, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00);
      // R5 R6: erase reads, hit then miss
      for (int i = 0; i < 3; i++) step(3'd2, 1'b1, 1'b1, 8'h12, 1'b0, 1'b1, 8'h00);
      for (int i = 0; i < 2; i++) step(3'd2, 1'b1, 1'b0, 8'h12, 1'b1, 1'b0, 8'h00);
      // R7: suspended-sector reads freeze bit 6, bit 2 moves
      for (int i = 0; i < 3; i++) step(3'd3, 1'b1, 1'b1, 8'hFF, 1'b1, 1'b1, 8'h0F);
      // R8: other sectors read array data
      step(3'd3, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b1, 8'hC3);
      // R9: program during suspend
      for (int i = 0; i < 2; i++) step(3'd4, 1'b1, 1'b1, 8'h7F, 1'b1, 1'b1, 8'hFF);
      // constrained random
      for (int i = 0; i < N_RANDOM; i++) begin
         step(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
              1'($urandom_range(0, 1)), 8'($urandom), 1'($urandom_range(0, 3) == 0),
              1'($urandom_range(0, 1)), 8'($urandom));
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule